// File: doc/BRIEF.md
# ADC Conversion Mode Sequencer

This block is the digital control core of a 16-input, 12-bit successive-approximation converter. A serial front end delivers 8-bit command bytes that have already been deserialised. The block decodes them into a setup register and a conversion register. The setup register holds a 2-bit clock mode, and that mode decides three things: how a conversion is launched (a falling edge on the start pin, a conversion-register write, or serial clock ticks that time the acquisition), whether a channel scan and averaging are allowed, and when the active-low end-of-conversion flag goes low.

The analog path is modelled as a fixed-latency engine. It counts a parameterised number of internal clocks or, in the externally timed mode, that number of serial clock ticks. It then captures the 12-bit unsigned code presented for the currently selected channel. Each finished result, tagged with its channel, goes into a first-word-fall-through result FIFO that the host drains.

The sequencer has three states. IDLE goes to CONVERT on a launch. CONVERT restarts the engine while averaging samples remain and goes to STORE when the last sample of a channel arrives. STORE pushes the result and then either goes back to CONVERT for the next channel (advance) or returns to IDLE when the last channel is done (finish). A setup write that changes the mode forces IDLE from any state (abort).

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the clock mode is 2'b10, `eoc_n` is high and the result FIFO is empty.
- R2: Command bytes are decoded as follows. A byte with bit 7 = 1 is a conversion-register write: bits 6:3 are the channel number N and bit 1 is the scan enable. A byte with bits 7:6 = 2'b01 is a setup write: bits 5:4 are the clock mode (bit 5 is the upper bit) and bit 2 is the averaging enable. A byte with bits 7:6 = 2'b00 is ignored.
- R3: In mode 2'b10 a conversion-register write launches an internally timed sequence. With scan enabled it converts channels 0 up to N in ascending order; otherwise it converts only channel N. Start-pin edges have no effect in this mode.
- R4: In mode 2'b00 a conversion-register write only stores N and the scan enable. A falling edge on `cnvst_n` launches the stored sequence.
- R5: In mode 2'b01 each falling edge on `cnvst_n` converts channel N exactly once, whatever the scan enable says. `eoc_n` goes low after that single result.
- R6: In mode 2'b11 a conversion-register write converts channel N once. The conversion completes after CONV_CYCLES `sclk_tick` pulses, scan and averaging are ignored, and `eoc_n` stays high.
- R7: In modes 2'b00 and 2'b10, `eoc_n` goes low in the cycle after the last result of the sequence is pushed, and at no earlier point of the sequence.
- R8: A falling edge on `cs_n` or on `cnvst_n` returns `eoc_n` high in the next cycle.
- R9: With averaging enabled (modes other than 2'b11), each channel's result is the floor of the mean of 2**AVG_LOG2 consecutive conversions, so each channel takes that many conversion times.
- R10: Each FIFO entry is {channel[3:0], code[11:0]}, holding the code present on `ana_code` at the end of the conversion. Entries come out in push order. The head entry is visible on `rd_data` and `rd_en` removes it.
- R11: A launch request (start-pin edge or conversion-register write) that arrives while a sequence is running is ignored and produces no extra results.
- R12: A setup write that changes the clock mode aborts any sequence, returns to IDLE and drives `eoc_n` high, and no further results of that sequence are pushed. A setup write that keeps the same mode does not abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_byte` holds a received command byte |
| cmd_byte | input | 8 | Received command byte |
| cs_n | input | 1 | Serial chip select, active low |
| cnvst_n | input | 1 | Conversion start pin, falling edge active |
| sclk_tick | input | 1 | One pulse per serial clock, used for externally timed acquisition |
| ana_code | input | 12 | Digitised code of the currently selected channel |
| mux_ch | output | 4 | Channel currently selected for conversion |
| eoc_n | output | 1 | End-of-conversion flag, active low |
| rd_en | input | 1 | Pop the head result |
| rd_data | output | 16 | Head result {channel, code} |
| rd_empty | output | 1 | Result FIFO is empty |

## Verification
The assertions assume that `cs_n`, `cnvst_n`, `cmd_valid` and `sclk_tick` are already synchronous to `clk`. They also assume that `cmd_valid` is a single-cycle strobe, so a mode change and a launch request never come from the same byte, and that the host never lets the FIFO overflow. The stimulus keeps within these limits. It changes every input only on the falling clock edge, holds strobes for exactly one cycle, drains the FIFO after each scenario, and keeps the longest scan below the FIFO depth. Start-pin and chip-select pulses are spaced far enough apart that a release never lands in the same cycle as a sequence end.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W   = 4;
    localparam int CODE_W = 12;

    typedef enum logic [1:0] {
        MODE_PIN_SEQ = 2'b00,
        MODE_PIN_ONE = 2'b01,
        MODE_SER_SEQ = 2'b10,
        MODE_EXT_CLK = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_STORE
    } seq_state_e;

endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_byte,
    output clk_mode_e       mode_q,
    output logic            avg_q,
    output logic [CH_W-1:0] ch_eff,
    output logic            scan_eff,
    output logic            conv_wr,
    output logic            mode_chg
);

    logic            setup_wr;
    clk_mode_e       new_mode;
    logic [CH_W-1:0] ch_q;
    logic            scan_q;
    logic            unused_bit0;

    assign unused_bit0 = cmd_byte[0];
    assign conv_wr     = cmd_valid && cmd_byte[7];
    assign setup_wr    = cmd_valid && (cmd_byte[7:6] == 2'b01);
    assign new_mode    = clk_mode_e'(cmd_byte[5:4]);
    assign mode_chg    = setup_wr && (new_mode != mode_q);

    // a conversion write is visible in the same cycle it arrives
    assign ch_eff   = conv_wr ? cmd_byte[6:3] : ch_q;
    assign scan_eff = conv_wr ? cmd_byte[1]   : scan_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SER_SEQ;
            avg_q  <= 1'b0;
            ch_q   <= '0;
            scan_q <= 1'b0;
        end else begin
            if (setup_wr) begin
                mode_q <= new_mode;
                avg_q  <= cmd_byte[2];
            end
            if (conv_wr) begin
                ch_q   <= cmd_byte[6:3];
                scan_q <= cmd_byte[1];
            end
        end
    end

    AST_MODE_ONLY_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(setup_wr)); // R2

endmodule

// File: rtl/adc_conv_engine.sv
module adc_conv_engine
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              ext_time,
    input  logic              sclk_tick,
    input  logic [CODE_W-1:0] ana_code,
    output logic              done,
    output logic [CODE_W-1:0] code
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    logic             busy;
    logic             ext_q;
    logic [CNT_W-1:0] cnt;
    logic             step;

    // internal timing advances every clock, external timing only on serial ticks
    assign step = busy && (!ext_q || sclk_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            ext_q <= 1'b0;
            cnt   <= '0;
            done  <= 1'b0;
            code  <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                busy  <= 1'b1;
                ext_q <= ext_time;
                cnt   <= CNT_W'(CONV_CYCLES - 1);
            end else if (step) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    code <= ana_code;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R11

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      count;
    logic             full;
    logic             do_wr;
    logic             do_rd;

    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH)); // R10
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> !empty); // R10

endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 6,
    parameter int AVG_LOG2    = 2,
    parameter int FIFO_DEPTH  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [7:0]             cmd_byte,
    input  logic                   cs_n,
    input  logic                   cnvst_n,
    input  logic                   sclk_tick,
    input  logic [CODE_W-1:0]      ana_code,
    output logic [CH_W-1:0]        mux_ch,
    output logic                   eoc_n,
    input  logic                   rd_en,
    output logic [CH_W+CODE_W-1:0] rd_data,
    output logic                   rd_empty
);

    localparam int AVG_N = 1 << AVG_LOG2;
    localparam int ACC_W = CODE_W + AVG_LOG2;
    localparam int AC_W  = AVG_LOG2 + 1;
    localparam int RES_W = CH_W + CODE_W;

    clk_mode_e       mode_q;
    logic            avg_q, scan_eff, conv_wr, mode_chg;
    logic [CH_W-1:0] ch_eff;

    adc_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .mode_q(mode_q), .avg_q(avg_q), .ch_eff(ch_eff), .scan_eff(scan_eff),
        .conv_wr(conv_wr), .mode_chg(mode_chg)
    );

    // edge detection on the two release/launch pins
    logic cs_q, cnv_q, cs_fall, cnv_fall;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            cnv_q <= 1'b1;
        end else begin
            cs_q  <= cs_n;
            cnv_q <= cnvst_n;
        end
    end
    assign cs_fall  = cs_q && !cs_n;
    assign cnv_fall = cnv_q && !cnvst_n;

    // mode-dependent launch decode
    logic start_req, start_scan, start_avg, start_ext;
    always_comb begin
        unique case (mode_q)
            MODE_PIN_SEQ: begin start_req = cnv_fall; start_scan = scan_eff; start_avg = avg_q; start_ext = 1'b0; end
            MODE_PIN_ONE: begin start_req = cnv_fall; start_scan = 1'b0;     start_avg = avg_q; start_ext = 1'b0; end
            MODE_SER_SEQ: begin start_req = conv_wr;  start_scan = scan_eff; start_avg = avg_q; start_ext = 1'b0; end
            MODE_EXT_CLK: begin start_req = conv_wr;  start_scan = 1'b0;     start_avg = 1'b0;  start_ext = 1'b1; end
        endcase
    end

    seq_state_e        state, state_d;
    logic [CH_W-1:0]   ch_cur, ch_last;
    logic              avg_on, ext_on;
    logic [AC_W-1:0]   avg_cnt;
    logic [ACC_W-1:0]  acc;
    logic              eng_done, eng_start, eng_ext;
    logic [CODE_W-1:0] eng_code;
    logic              launch, last_sample, is_last_ch, push, seq_end;
    logic [CODE_W-1:0] res_code;

    assign launch      = (state == ST_IDLE) && start_req && !mode_chg;
    assign last_sample = !avg_on || (avg_cnt == AC_W'(AVG_N - 1));
    assign is_last_ch  = (ch_cur == ch_last);

    // next-state process
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (launch) state_d = ST_CONVERT;
            ST_CONVERT: if (eng_done && last_sample) state_d = ST_STORE;
            ST_STORE:   state_d = is_last_ch ? ST_IDLE : ST_CONVERT;
        endcase
        if (mode_chg) state_d = ST_IDLE;
    end

    // output process
    always_comb begin
        eng_start = 1'b0;
        push      = 1'b0;
        unique case (state)
            ST_IDLE:    eng_start = launch;
            ST_CONVERT: eng_start = eng_done && !last_sample && !mode_chg;
            ST_STORE: begin
                push      = !mode_chg;
                eng_start = !is_last_ch && !mode_chg;
            end
        endcase
    end

    assign seq_end  = push && is_last_ch;
    assign eng_ext  = launch ? start_ext : ext_on;
    assign res_code = avg_on ? CODE_W'(acc >> AVG_LOG2) : acc[CODE_W-1:0];
    assign mux_ch   = ch_cur;

    // state register and sequence datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ch_cur  <= '0;
            ch_last <= '0;
            avg_on  <= 1'b0;
            ext_on  <= 1'b0;
            avg_cnt <= '0;
            acc     <= '0;
        end else begin
            state <= state_d;
            if (launch) begin
                ch_cur  <= start_scan ? '0 : ch_eff;
                ch_last <= ch_eff;
                avg_on  <= start_avg;
                ext_on  <= start_ext;
                avg_cnt <= '0;
                acc     <= '0;
            end else if (state == ST_CONVERT && eng_done) begin
                acc <= acc + ACC_W'(eng_code);
                if (!last_sample) avg_cnt <= avg_cnt + AC_W'(1);
            end else if (state == ST_STORE && !is_last_ch) begin
                ch_cur  <= ch_cur + CH_W'(1);
                avg_cnt <= '0;
                acc     <= '0;
            end
        end
    end

    // end-of-conversion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             eoc_n <= 1'b1;
        else if (mode_chg || mode_q == MODE_EXT_CLK) eoc_n <= 1'b1;
        else if (seq_end)                       eoc_n <= 1'b0;
        else if (cs_fall || cnv_fall)           eoc_n <= 1'b1;
    end

    adc_conv_engine #(.CONV_CYCLES(CONV_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .abort(mode_chg),
        .ext_time(eng_ext), .sclk_tick(sclk_tick), .ana_code(ana_code),
        .done(eng_done), .code(eng_code)
    );

    adc_result_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(RES_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din({ch_cur, res_code}),
        .pop(rd_en), .dout(rd_data), .empty(rd_empty)
    );

    AST_EOC_HIGH_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EXT_CLK) |-> eoc_n); // R6
    AST_EOC_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> $past(seq_end)); // R7
    AST_EOC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_fall || cnv_fall) && !seq_end) |=> eoc_n); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (state == ST_IDLE && !push)); // R12

endmodule

// File: tb/sim_adc_mode_seq.sv
module sim_adc_mode_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        cs_n = 1'b1;
    logic        cnvst_n = 1'b1;
    logic        sclk_tick = 1'b0;
    logic [11:0] ana_code;
    logic [3:0]  mux_ch;
    logic        eoc_n;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rd_empty;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // analog model: each channel presents a distinct code
    assign ana_code = 12'(int'(mux_ch) * 200 + 17);

    adc_mode_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cs_n(cs_n), .cnvst_n(cnvst_n), .sclk_tick(sclk_tick), .ana_code(ana_code),
        .mux_ch(mux_ch), .eoc_n(eoc_n), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty)
    );

    function automatic int exp_entry(input int ch);
        return ch * 4096 + ch * 200 + 17;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic setup_wr(input logic [1:0] mode, input logic avg);
        send({2'b01, mode, 1'b0, avg, 2'b00});
    endtask

    task automatic conv_wr(input logic [3:0] ch, input logic scan);
        send({1'b1, ch, 1'b0, scan, 1'b0});
    endtask

    task automatic pulse_cnvst;
        @(negedge clk);
        cnvst_n = 1'b0;
        @(negedge clk);
        cnvst_n = 1'b1;
    endtask

    task automatic wait_eoc_low(output int cyc);
        cyc = 0;
        while (eoc_n && cyc < 600) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic pop_expect(input int ch, input string req);
        chk(!rd_empty, req, "fifo has entry", int'(rd_empty), 0);
        chk(int'(rd_data) == exp_entry(ch), req, "entry {ch,code}", int'(rd_data), exp_entry(ch));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while (!rd_empty && n < 64) begin
            rd_en = 1'b1;
            @(negedge clk);
            n++;
        end
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        chk(eoc_n == 1'b1, "R1", "eoc_n after reset", int'(eoc_n), 1);
        chk(rd_empty == 1'b1, "R1", "fifo empty after reset", int'(rd_empty), 1);
    endtask

    int t_single;

    task automatic t_mode10;
        int cyc;
        // default mode: start pin must do nothing
        pulse_cnvst();
        idle(40);
        chk(rd_empty == 1'b1, "R3", "start pin ignored in mode 10", int'(rd_empty), 1);
        // scan 0..3 with a second request mid-run
        conv_wr(4'd3, 1'b1);
        conv_wr(4'd7, 1'b1);
        while (rd_empty) @(negedge clk);
        chk(eoc_n == 1'b1, "R7", "eoc_n high mid-sequence", int'(eoc_n), 1);
        wait_eoc_low(cyc);
        chk(eoc_n == 1'b0, "R7", "eoc_n low at sequence end", int'(eoc_n), 0);
        for (int c = 0; c < 4; c++) pop_expect(c, "R3");
        chk(rd_empty == 1'b1, "R11", "no extra results from ignored request", int'(rd_empty), 1);
        // chip select releases eoc
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk(eoc_n == 1'b1, "R8", "cs_n fall releases eoc_n", int'(eoc_n), 1);
        cs_n = 1'b1;
        // a 00-prefixed byte is ignored; mode 10 still serial-launched
        send(8'b0011_0000);
        conv_wr(4'd5, 1'b0);
        wait_eoc_low(t_single);
        chk(eoc_n == 1'b0, "R2", "ignored byte kept mode 10", int'(eoc_n), 0);
        pop_expect(5, "R3");
        chk(rd_empty == 1'b1, "R3", "non-scan converts only N", int'(rd_empty), 1);
    endtask

    task automatic t_mode00;
        int cyc;
        setup_wr(2'b00, 1'b0);
        conv_wr(4'd2, 1'b1);
        idle(40);
        chk(rd_empty == 1'b1, "R4", "write alone does not launch", int'(rd_empty), 1);
        pulse_cnvst();
        wait_eoc_low(cyc);
        chk(eoc_n == 1'b0, "R4", "eoc_n low after pin sequence", int'(eoc_n), 0);
        for (int c = 0; c < 3; c++) pop_expect(c, "R4");
        chk(rd_empty == 1'b1, "R4", "sequence length", int'(rd_empty), 1);
        pulse_cnvst();
        chk(eoc_n == 1'b1, "R8", "cnvst_n fall releases eoc_n", int'(eoc_n), 1);
        idle(3);
        pulse_cnvst();
        wait_eoc_low(cyc);
        for (int c = 0; c < 3; c++) pop_expect(c, "R11");
        chk(rd_empty == 1'b1, "R11", "pin request while busy ignored", int'(rd_empty), 1);
    endtask

    task automatic t_mode01;
        int cyc;
        setup_wr(2'b01, 1'b0);
        conv_wr(4'd4, 1'b1);
        pulse_cnvst();
        wait_eoc_low(cyc);
        chk(eoc_n == 1'b0, "R5", "eoc_n low after one conversion", int'(eoc_n), 0);
        pop_expect(4, "R5");
        chk(rd_empty == 1'b1, "R5", "one channel per pin edge", int'(rd_empty), 1);
        pulse_cnvst();
        chk(eoc_n == 1'b1, "R8", "pin edge releases eoc_n in mode 01", int'(eoc_n), 1);
        wait_eoc_low(cyc);
        pop_expect(4, "R5");
        chk(rd_empty == 1'b1, "R5", "second edge single result", int'(rd_empty), 1);
    endtask

    task automatic t_avg;
        int cyc;
        setup_wr(2'b10, 1'b1);
        conv_wr(4'd1, 1'b0);
        wait_eoc_low(cyc);
        chk(t_single <= 12, "R9", "single conversion latency", t_single, 12);
        chk(cyc >= 24 && cyc < 600, "R9", "averaged latency", cyc, 24);
        pop_expect(1, "R9");
        chk(rd_empty == 1'b1, "R9", "one averaged result", int'(rd_empty), 1);
    endtask

    task automatic t_mode11;
        setup_wr(2'b11, 1'b1);
        chk(eoc_n == 1'b1, "R6", "eoc_n high entering mode 11", int'(eoc_n), 1);
        conv_wr(4'd6, 1'b1);
        idle(30);
        chk(rd_empty == 1'b1, "R6", "no result without serial ticks", int'(rd_empty), 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) sclk_tick = 1'b1;
            @(negedge clk) sclk_tick = 1'b0;
            @(negedge clk);
        end
        idle(5);
        chk(rd_empty == 1'b1, "R6", "five ticks not enough", int'(rd_empty), 1);
        @(negedge clk) sclk_tick = 1'b1;
        @(negedge clk) sclk_tick = 1'b0;
        idle(4);
        pop_expect(6, "R6");
        chk(rd_empty == 1'b1, "R6", "scan and averaging ignored", int'(rd_empty), 1);
        chk(eoc_n == 1'b1, "R6", "eoc_n stays high in mode 11", int'(eoc_n), 1);
    endtask

    task automatic t_abort;
        int cyc;
        int n;
        setup_wr(2'b10, 1'b0);
        conv_wr(4'd2, 1'b1);
        idle(3);
        setup_wr(2'b10, 1'b1);
        wait_eoc_low(cyc);
        for (int c = 0; c < 3; c++) pop_expect(c, "R12");
        chk(rd_empty == 1'b1, "R12", "same-mode write did not abort", int'(rd_empty), 1);
        conv_wr(4'd7, 1'b1);
        idle(10);
        setup_wr(2'b00, 1'b0);
        idle(100);
        drain(n);
        chk(n <= 2, "R12", "aborted sequence stopped early", n, 2);
        idle(60);
        chk(rd_empty == 1'b1, "R12", "no results after abort", int'(rd_empty), 1);
        chk(eoc_n == 1'b1, "R12", "eoc_n high after abort", int'(eoc_n), 1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_mode10();
        t_mode00();
        t_mode01();
        t_avg();
        t_mode11();
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all-R actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule